// File: doc/BRIEF.md
# Write-Back Three-State Snooping Coherence Controller

This block is the coherence controller for one direct-mapped, write-back cache that shares a snooping bus with other caches. Every line is held in one of three states: invalid (no data), shared (clean and read-only) or exclusive (the single copy, writable and dirty). The controller serves processor reads and writes from the line store. On a miss it masters the bus to fetch the block. When the line it must replace is dirty, it first writes that line back.

At the same time it watches the read misses and write misses that other caches place on the bus. When such a miss names a block this cache owns dirty, the controller drives the block onto a supply bus in that same cycle and raises an abort, so that memory does not answer. It then downgrades the line (to shared on a read miss) or drops it (on a write miss). Each block is one data word. The line index is the low address bits and the tag is the rest.

Bus command codes: 2'b00 none, 2'b01 read miss, 2'b10 write miss, 2'b11 write-back. A bus transaction completes in the cycle where `bus_gnt` and `bus_done` are both high.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `sup_abort` are low, and the first access to any address misses.
- R2: A processor read that misses (line invalid or tag differs) issues a read miss (code 2'b01) at the processor address. It completes with the bus fill data and leaves the line shared.
- R3: A processor write to a line that is invalid, shared or holds another tag issues a write miss (code 2'b10). It completes with the line exclusive and holding the written data.
- R4: A read hit in shared or exclusive, and a write hit in exclusive, complete in the request cycle. They start no bus transaction and leave the state unchanged.
- R5: A miss whose line is exclusive under another tag first issues a write-back (code 2'b11) carrying the victim address and data. Only after that transfer completes does it issue the new miss.
- R6: A read miss that replaces a shared line of another tag issues only the read miss, with no write-back.
- R7: A snooped read miss (snoop code 2'b01) to a block held exclusive raises `sup_abort` in the same cycle with the block on `sup_data`. The line becomes shared.
- R8: A snooped write miss (snoop code 2'b10) to a block held exclusive raises `sup_abort` with the block on `sup_data`. The line becomes invalid.
- R9: A snooped write miss to a block held shared invalidates it without raising `sup_abort`. A snoop whose tag differs from the line, or whose line is invalid, has no effect.
- R10: When a snoop and a processor request name the same line in one cycle, the snoop is applied first. The processor request is not answered in that cycle and is re-checked against the updated state.
- R11: While a miss transaction is outstanding, `bus_req` stays high with a stable command and address until it completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | Bus command code |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Current transaction finishes |
| bus_rdata | input | DATA_W | Fill data for a miss |
| snp_valid | input | 1 | Another cache's miss is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| sup_abort | output | 1 | This cache supplies the block and cancels memory's reply |
| sup_data | output | DATA_W | Supplied block data |

## Verification
The snoop port and the processor port can name the same line in a single cycle. The contention case has a snooped write miss arrive in the same cycle as a processor read of a line held exclusive. It is judged from the ports: in that cycle `sup_abort` must be high and `cpu_ready` low. The read must then go to the bus as a read miss and return the memory fill value, not the data that hit before. A dirty eviction is also judged by the order of the logged bus transfers: the write-back must come before the miss.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              sup_abort,
  output logic [DATA_W-1:0] sup_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] L_INV = 2'd0, L_SHR = 2'd1, L_EXC = 2'd2;
  localparam logic [1:0] C_NONE = 2'b00, C_RDM = 2'b01, C_WRM = 2'b10, C_WB = 2'b11;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_MISS} fsm_t;
  fsm_t fsm_q;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  logic c_match, hit, clash, go, victim_dirty, wb_live, xfer_done, snp_hit;
  assign c_match      = tag_q[c_idx] == c_tag;
  assign hit          = c_match && (cpu_we ? st_q[c_idx] == L_EXC : st_q[c_idx] != L_INV);
  assign clash        = snp_valid && s_idx == c_idx;
  assign go           = fsm_q == F_IDLE && cpu_req && !clash;
  assign victim_dirty = st_q[c_idx] == L_EXC && !c_match;
  assign wb_live      = fsm_q == F_WB && victim_dirty;
  assign xfer_done    = bus_gnt && bus_done;
  assign snp_hit      = snp_valid && st_q[s_idx] != L_INV && tag_q[s_idx] == s_tag;

  assign sup_abort = snp_hit && st_q[s_idx] == L_EXC;
  assign sup_data  = dat_q[s_idx];

  assign cpu_ready = (go && hit) || (fsm_q == F_MISS && xfer_done);
  assign cpu_rdata = (fsm_q == F_MISS) ? (cpu_we ? cpu_wdata : bus_rdata) : dat_q[c_idx];

  assign bus_req   = wb_live || fsm_q == F_MISS;
  assign bus_cmd   = wb_live ? C_WB : (fsm_q == F_MISS) ? (cpu_we ? C_WRM : C_RDM) : C_NONE;
  assign bus_addr  = wb_live ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = dat_q[c_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q <= F_IDLE;
    end else begin
      case (fsm_q)
        F_IDLE: if (go && !hit) fsm_q <= victim_dirty ? F_WB : F_MISS;
        F_WB:   if (!wb_live || xfer_done) fsm_q <= F_MISS;
        F_MISS: if (xfer_done) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= L_INV;
    end else begin
      if (wb_live && xfer_done) st_q[c_idx] <= L_INV;
      if (fsm_q == F_MISS && xfer_done) st_q[c_idx] <= cpu_we ? L_EXC : L_SHR;
      if (snp_hit) begin
        if (snp_cmd == C_WRM) st_q[s_idx] <= L_INV;
        else if (snp_cmd == C_RDM && st_q[s_idx] == L_EXC) st_q[s_idx] <= L_SHR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && hit && cpu_we) dat_q[c_idx] <= cpu_wdata;
    if (fsm_q == F_MISS && xfer_done) begin
      tag_q[c_idx] <= c_tag;
      dat_q[c_idx] <= cpu_we ? cpu_wdata : bus_rdata;
    end
  end

  // R2
  rd_done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |=> st_q[$past(c_idx)] != L_INV);
  // R3
  wr_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> st_q[$past(c_idx)] == L_EXC);
  // R5
  wb_victim_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == C_WB) |-> bus_addr != cpu_addr);
  // R7
  snp_rd_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_abort && snp_cmd == C_RDM) |=> st_q[$past(s_idx)] == L_SHR);
  // R9
  snp_wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd == C_WRM) |=> st_q[$past(s_idx)] == L_INV);
  // R11
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_MISS && !xfer_done) |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));
endmodule

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready;
  logic [7:0] cpu_rdata;
  logic bus_req, bus_gnt, bus_done;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic sup_abort;
  logic [7:0] sup_data;

  msi_snoop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .sup_abort(sup_abort), .sup_data(sup_data));

  assign bus_gnt   = bus_req;
  assign bus_rdata = bus_addr ^ 8'h5A;
  logic [1:0] wait_q = 0;
  logic done_q = 0;
  assign bus_done = done_q;
  always @(posedge clk) begin
    if (!bus_req || done_q) begin done_q <= 0; wait_q <= 0; end
    else if (wait_q == 1) done_q <= 1;
    else wait_q <= wait_q + 1;
  end

  logic [1:0] log_cmd [64];
  logic [7:0] log_addr [64];
  logic [7:0] log_data [64];
  int n_log = 0;
  always @(posedge clk) if (bus_req && bus_gnt && bus_done && n_log < 64) begin
    log_cmd[n_log] = bus_cmd; log_addr[n_log] = bus_addr; log_data[n_log] = bus_wdata;
    n_log = n_log + 1;
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic ab, output logic [7:0] sd);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1; ab = sup_abort; sd = sup_data;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] rd;
    int s;
    #1;
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 sup_abort after reset", sup_abort, 0);
    s = n_log;
    access(0, 8'h04, 0, rd);
    chk("R1 first access misses", n_log - s, 1);
    chk("R2 read miss command", log_cmd[s], 2'b01);
    chk("R2 read miss address", log_addr[s], 8'h04);
    chk("R2 fill data", rd, 8'h04 ^ 8'h5A);
  endtask

  task automatic t_hits_and_upgrade();
    logic [7:0] rd;
    int s;
    s = n_log;
    access(0, 8'h04, 0, rd);
    chk("R4 read hit in shared, no bus", n_log - s, 0);
    chk("R4 read hit data", rd, 8'h04 ^ 8'h5A);
    access(1, 8'h04, 8'h77, rd);
    chk("R3 write to shared issues one transfer", n_log - s, 1);
    chk("R3 write miss command", log_cmd[s], 2'b10);
    s = n_log;
    access(1, 8'h04, 8'h78, rd);
    access(0, 8'h04, 0, rd);
    chk("R4 write and read hit in exclusive, no bus", n_log - s, 0);
    chk("R3 written data held", rd, 8'h78);
  endtask

  task automatic t_snoop_excl_read();
    logic ab; logic [7:0] sd, rd;
    int s;
    snoop(2'b01, 8'h04, ab, sd);
    chk("R7 abort on read snoop", ab, 1);
    chk("R7 supplied data", sd, 8'h78);
    snoop(2'b10, 8'h04, ab, sd);
    chk("R9 no abort on write snoop to shared", ab, 0);
    s = n_log;
    access(0, 8'h04, 0, rd);
    chk("R9 line invalid after write snoop", n_log - s, 1);
    chk("R9 refetch is read miss", log_cmd[s], 2'b01);
  endtask

  task automatic t_dirty_evict();
    logic ab; logic [7:0] sd, rd;
    int s;
    access(1, 8'h05, 8'h11, rd);
    s = n_log;
    access(0, 8'h09, 0, rd);
    chk("R5 two transfers", n_log - s, 2);
    chk("R5 write-back first", log_cmd[s], 2'b11);
    chk("R5 victim address", log_addr[s], 8'h05);
    chk("R5 victim data", log_data[s], 8'h11);
    chk("R5 miss after write-back", log_cmd[s+1], 2'b01);
    chk("R5 miss address", log_addr[s+1], 8'h09);
    chk("R5 fill", rd, 8'h09 ^ 8'h5A);
    snoop(2'b01, 8'h05, ab, sd);
    chk("R9 evicted block not supplied", ab, 0);
  endtask

  task automatic t_clean_replace();
    logic [7:0] rd;
    int s;
    s = n_log;
    access(0, 8'h0D, 0, rd);
    chk("R6 only one transfer", n_log - s, 1);
    chk("R6 it is a read miss", log_cmd[s], 2'b01);
  endtask

  task automatic t_snoop_excl_write();
    logic ab; logic [7:0] sd, rd;
    access(1, 8'h02, 8'h33, rd);
    snoop(2'b10, 8'h02, ab, sd);
    chk("R8 abort on write snoop", ab, 1);
    chk("R8 supplied data", sd, 8'h33);
    snoop(2'b01, 8'h02, ab, sd);
    chk("R8 line invalid afterwards", ab, 0);
  endtask

  task automatic t_tag_mismatch();
    logic ab; logic [7:0] sd, rd;
    int s;
    access(1, 8'h03, 8'h44, rd);
    snoop(2'b10, 8'h07, ab, sd);
    chk("R9 other-tag snoop no abort", ab, 0);
    s = n_log;
    access(0, 8'h03, 0, rd);
    chk("R9 line untouched, hit", n_log - s, 0);
    chk("R9 data untouched", rd, 8'h44);
  endtask

  task automatic t_clash();
    logic ab, rdy;
    logic [7:0] rd;
    int s;
    s = n_log;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h03;
    snp_valid = 1; snp_cmd = 2'b10; snp_addr = 8'h03;
    #1; ab = sup_abort; rdy = cpu_ready;
    chk("R10 snoop served in clash cycle", ab, 1);
    chk("R10 processor held in clash cycle", rdy, 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
    chk("R10 re-check issues read miss", n_log - s, 1);
    chk("R10 read miss command", log_cmd[s], 2'b01);
    chk("R10 data from memory", rd, 8'h03 ^ 8'h5A);
  endtask

  task automatic t_hold();
    logic [7:0] rd;
    int stable_bad = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h0E; cpu_wdata = 8'h21;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      if (!cpu_ready && (!bus_req || bus_cmd != 2'b10 || bus_addr != 8'h0E)) stable_bad++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
    chk("R11 request held stable", stable_bad, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (20000) @(posedge clk);
    wd_hit = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_hits_and_upgrade();
        t_snoop_excl_read();
        t_dirty_evict();
        t_clean_replace();
        t_snoop_excl_write();
        t_tag_mismatch();
        t_clash();
        t_hold();
      end
      begin
        wait (wd_hit);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule